// File: doc/BRIEF.md
# Path-History Indirect Target Predictor

This block supplies predicted targets for indirect branches at fetch time. It keeps a 15-bit register that summarises the recent path of taken branches. A lookup hashes the current path register with the branch address to pick one entry of a 256-entry direct-mapped target table. A match is reported only when the main target buffer has also recognised the branch.

A retire-side event port reports each branch as it completes: its kind, whether it was taken, its address and its target. Taken conditional branches and taken indirect branches fold address and target bits into the path register. Every other branch event leaves the register alone. When a taken indirect branch retires and its table entry is missing or holds a different target, the entry is rewritten.

The rewrite uses the path value that was captured at the most recent lookup. The caller therefore retires an indirect branch before it issues the next lookup. Address inputs carry only the address bits [18:4] that the block consumes: port bit k holds address bit k+4.

Top module: `pathIndirectPredictor`

## Requirements
- R1: After reset the path register is zero and every table entry is empty, so no lookup reports a prediction until an entry has been written.
- R2: A retire event of kind 0 (conditional) with taken=1 sets the path register to (old value shifted left by 2, truncated to 15 bits) XOR address bits [18:4].
- R3: A retire event of kind 1 (indirect) with taken=1 sets the path register to (old value shifted left by 2) XOR the 15-bit value {2'b00, address bits [18:12], target bits [5:0]}.
- R4: The path register is left unchanged by four kinds of event: a not-taken conditional, kind 2 (direct jump), kind 3 (call or return), and an indirect with taken=0.
- R5: The hash is {A[12]^P[14], A[11:4]^P[13:6], A[18:13]^P[5:0]}, where A is the address and P is the path register. Hash bits [13:6] form the table index. The 7-bit tag is {hash[14], hash[5:0]}.
- R6: A prediction is reported only for a lookup whose main-buffer hit input is 1, and only if the indexed entry is valid with an equal tag.
- R7: A taken indirect retire whose entry is empty, carries a different tag, or holds a different target writes the new tag and target into that entry. The hash for this write uses the path value captured at the last lookup.
- R8: The prediction flag and the target appear on the clock edge that samples the lookup. The target output is zero when no prediction is made.
- R9: A branch's influence on the path register ends after 8 further updates, so identical sequences of 8 taken conditionals give identical path values whatever came before them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup request this cycle |
| lookupPc | input | 15 | Address bits [18:4] of the looked-up branch |
| btbHit | input | 1 | Main target buffer hit for this lookup |
| retValid | input | 1 | Retire event this cycle |
| retKind | input | 2 | 0 conditional, 1 indirect, 2 direct jump, 3 call/return |
| retTaken | input | 1 | Retired branch was taken |
| retPc | input | 15 | Address bits [18:4] of the retired branch |
| retTarget | input | TGT_W | Resolved target of the retired branch |
| predValid | output | 1 | Prediction made for the previous-edge lookup |
| predTarget | output | TGT_W | Predicted target, zero when predValid is 0 |

## Verification
The bench flushes the path register with eight fixed taken conditionals so that later lookups land on trained entries. A design whose history lasts longer than 8 updates would then miss where hits are expected. Two addresses that differ only in address bit 13 share an index but differ in tag. A design that drops a tag bit would return the wrong target for one of them instead of missing. The bench also issues not-taken conditionals, jumps and calls between training and lookup, which catches a path register that moves on ignored kinds. Finally, lookups with the main-buffer hit input low must never predict.

// File: rtl/itpPkg.sv
`timescale 1ns/1ps
package itpPkg;
  localparam int PIR_W   = 15;
  localparam int IDX_W   = 8;
  localparam int TAG_W   = 7;
  localparam int ENTRIES = 1 << IDX_W;

  typedef enum logic [1:0] {
    BR_COND     = 2'd0,
    BR_INDIRECT = 2'd1,
    BR_JUMP     = 2'd2,
    BR_CALLRET  = 2'd3
  } brKind_e;

  typedef struct packed {
    logic lookupEn;
    logic pirCond;
    logic pirInd;
    logic tableWrite;
  } ctlStrobes_t;

  // pcBits holds address bits [18:4]; pcBits[k] is address bit k+4
  function automatic logic [PIR_W-1:0] hashOf(input logic [14:0] pcBits,
                                              input logic [PIR_W-1:0] pir);
    hashOf = {pcBits[8] ^ pir[14], pcBits[7:0] ^ pir[13:6], pcBits[14:9] ^ pir[5:0]};
  endfunction
endpackage

// File: rtl/itpControl.sv
`timescale 1ns/1ps
module itpControl
  import itpPkg::*;
(
  input  logic        lookupValid,
  input  logic        retValid,
  input  logic [1:0]  retKind,
  input  logic        retTaken,
  input  logic        entryMatch,
  output ctlStrobes_t strobes
);
  brKind_e kind;
  logic    takenInd;

  always_comb begin
    kind               = brKind_e'(retKind);
    takenInd           = retValid && retTaken && (kind == BR_INDIRECT);
    strobes.lookupEn   = lookupValid;
    strobes.pirCond    = retValid && retTaken && (kind == BR_COND);
    strobes.pirInd     = takenInd;
    strobes.tableWrite = takenInd && !entryMatch;
  end
endmodule

// File: rtl/itpDatapath.sv
`timescale 1ns/1ps
module itpDatapath
  import itpPkg::*;
#(
  parameter int TGT_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strobes,
  input  logic [14:0]        lookupPc,
  input  logic               btbHit,
  input  logic [14:0]        retPc,
  input  logic [TGT_W-1:0]   retTarget,
  output logic               predValid,
  output logic [TGT_W-1:0]   predTarget,
  output logic [PIR_W-1:0]   pirNow,
  output logic               entryMatch
);
  logic [PIR_W-1:0]   pirQ, lookPirQ, pirShifted, pirNext;
  logic [ENTRIES-1:0] entValidQ;
  logic [TAG_W-1:0]   entTagQ [ENTRIES];
  logic [TGT_W-1:0]   entTgtQ [ENTRIES];

  logic [PIR_W-1:0] lkHash, rtHash;
  logic [IDX_W-1:0] lkIdx, rtIdx;
  logic [TAG_W-1:0] lkTag, rtTag;
  logic             lkHit;

  always_comb begin
    lkHash = hashOf(lookupPc, pirQ);
    lkIdx  = lkHash[13:6];
    lkTag  = {lkHash[14], lkHash[5:0]};
    lkHit  = entValidQ[lkIdx] && (entTagQ[lkIdx] == lkTag);

    rtHash = hashOf(retPc, lookPirQ);
    rtIdx  = rtHash[13:6];
    rtTag  = {rtHash[14], rtHash[5:0]};
    entryMatch = entValidQ[rtIdx] && (entTagQ[rtIdx] == rtTag) &&
                 (entTgtQ[rtIdx] == retTarget);

    pirShifted = {pirQ[PIR_W-3:0], 2'b00};
    pirNext    = pirQ;
    if (strobes.pirCond)
      pirNext = pirShifted ^ retPc;
    else if (strobes.pirInd)
      pirNext = pirShifted ^ {2'b00, retPc[14:8], retTarget[5:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pirQ       <= '0;
      lookPirQ   <= '0;
      entValidQ  <= '0;
      predValid  <= 1'b0;
      predTarget <= '0;
    end else begin
      pirQ <= pirNext;
      if (strobes.lookupEn)
        lookPirQ <= pirQ;
      if (strobes.tableWrite)
        entValidQ[rtIdx] <= 1'b1;
      predValid  <= strobes.lookupEn && btbHit && lkHit;
      predTarget <= (strobes.lookupEn && btbHit && lkHit) ? entTgtQ[lkIdx] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.tableWrite) begin
      entTagQ[rtIdx] <= rtTag;
      entTgtQ[rtIdx] <= retTarget;
    end
  end

  assign pirNow = pirQ;
endmodule

// File: rtl/pathIndirectPredictor.sv
`timescale 1ns/1ps
module pathIndirectPredictor
  import itpPkg::*;
#(
  parameter int TGT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic [14:0]      lookupPc,
  input  logic             btbHit,
  input  logic             retValid,
  input  logic [1:0]       retKind,
  input  logic             retTaken,
  input  logic [14:0]      retPc,
  input  logic [TGT_W-1:0] retTarget,
  output logic             predValid,
  output logic [TGT_W-1:0] predTarget
);
  ctlStrobes_t      strobes;
  logic             entryMatch;
  logic [PIR_W-1:0] pirNow;

  itpControl uCtl (
    .lookupValid(lookupValid),
    .retValid   (retValid),
    .retKind    (retKind),
    .retTaken   (retTaken),
    .entryMatch (entryMatch),
    .strobes    (strobes)
  );

  itpDatapath #(.TGT_W(TGT_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .lookupPc  (lookupPc),
    .btbHit    (btbHit),
    .retPc     (retPc),
    .retTarget (retTarget),
    .predValid (predValid),
    .predTarget(predTarget),
    .pirNow    (pirNow),
    .entryMatch(entryMatch)
  );
endmodule

// File: rtl/pathIndirectPredictorChecker.sv
`timescale 1ns/1ps
module pathIndirectPredictorChecker #(
  parameter int TGT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             lookupValid,
  input logic             btbHit,
  input logic             retValid,
  input logic [1:0]       retKind,
  input logic             retTaken,
  input logic [14:0]      retPc,
  input logic [TGT_W-1:0] retTarget,
  input logic             predValid,
  input logic [TGT_W-1:0] predTarget,
  input logic [14:0]      pirNow
);
  AST_PRED_NEEDS_BTB: assert property (@(posedge clk) disable iff (!rstN)
    predValid |-> $past(lookupValid && btbHit)); // R6

  AST_MISS_TARGET_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !predValid |-> (predTarget == '0)); // R8

  AST_COND_PIR: assert property (@(posedge clk) disable iff (!rstN)
    (retValid && retKind == 2'd0 && retTaken) |=>
      (pirNow == ({$past(pirNow[12:0]), 2'b00} ^ $past(retPc)))); // R2

  AST_IND_PIR: assert property (@(posedge clk) disable iff (!rstN)
    (retValid && retKind == 2'd1 && retTaken) |=>
      (pirNow == ({$past(pirNow[12:0]), 2'b00} ^
                  {2'b00, $past(retPc[14:8]), $past(retTarget[5:0])}))); // R3

  AST_IGNORED_PIR: assert property (@(posedge clk) disable iff (!rstN)
    (!retValid || retKind[1] || !retTaken) |=> $stable(pirNow)); // R4
endmodule

bind pathIndirectPredictor pathIndirectPredictorChecker #(.TGT_W(TGT_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .lookupValid(lookupValid),
  .btbHit     (btbHit),
  .retValid   (retValid),
  .retKind    (retKind),
  .retTaken   (retTaken),
  .retPc      (retPc),
  .retTarget  (retTarget),
  .predValid  (predValid),
  .predTarget (predTarget),
  .pirNow     (pirNow)
);

// File: tb/pathIndirectPredictor_test.sv
`timescale 1ns/1ps
module pathIndirectPredictor_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        lookupValid, btbHit, retValid, retTaken;
  logic [14:0] lookupPc, retPc;
  logic [1:0]  retKind;
  logic [31:0] retTarget, predTarget;
  logic        predValid;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  pathIndirectPredictor #(.TGT_W(32)) uut (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupPc(lookupPc),
    .btbHit(btbHit), .retValid(retValid), .retKind(retKind), .retTaken(retTaken),
    .retPc(retPc), .retTarget(retTarget), .predValid(predValid), .predTarget(predTarget)
  );

  // reference model
  logic [14:0] mPir, mLook;
  logic        mValid [256];
  logic [6:0]  mTag   [256];
  logic [31:0] mTgt   [256];

  function automatic logic [7:0] mIdx(input logic [14:0] pc, input logic [14:0] p);
    return pc[7:0] ^ p[13:6];
  endfunction
  function automatic logic [6:0] mTagOf(input logic [14:0] pc, input logic [14:0] p);
    return {pc[8] ^ p[14], pc[14:9] ^ p[5:0]};
  endfunction

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual valid=%0b tgt=%h expected valid=%0b tgt=%h",
               req, act[32], act[31:0], exp[32], exp[31:0]);
    end
  endtask

  task automatic lookup(input logic [14:0] pc, input logic btb, input string req,
                        output logic gotValid);
    logic [7:0]  idx;
    logic        ev;
    logic [31:0] et;
    @(negedge clk);
    lookupValid = 1'b1; lookupPc = pc; btbHit = btb;
    idx = mIdx(pc, mPir);
    ev  = btb && mValid[idx] && (mTag[idx] == mTagOf(pc, mPir));
    et  = ev ? mTgt[idx] : 32'd0;
    mLook = mPir;
    @(negedge clk);
    lookupValid = 1'b0; btbHit = 1'b0;
    check(req, {predValid, predTarget}, {ev, et});
    gotValid = predValid;
  endtask

  task automatic retire(input logic [1:0] kind, input logic taken,
                        input logic [14:0] pc, input logic [31:0] tgt);
    logic [7:0] idx;
    @(negedge clk);
    retValid = 1'b1; retKind = kind; retTaken = taken; retPc = pc; retTarget = tgt;
    if (kind == 2'd1 && taken) begin
      idx = mIdx(pc, mLook);
      mValid[idx] = 1'b1;
      mTag[idx]   = mTagOf(pc, mLook);
      mTgt[idx]   = tgt;
      mPir = {mPir[12:0], 2'b00} ^ {2'b00, pc[14:8], tgt[5:0]};
    end else if (kind == 2'd0 && taken) begin
      mPir = {mPir[12:0], 2'b00} ^ pc;
    end
    @(negedge clk);
    retValid = 1'b0;
  endtask

  task automatic flush();
    for (int i = 0; i < 8; i++) retire(2'd0, 1'b1, 15'h1000 + 15'(i * 37), 32'd0);
  endtask

  localparam logic [14:0] PC_A = 15'h0123;
  localparam logic [14:0] PC_B = 15'h0123 ^ 15'h0200; // differs in address bit 13
  localparam logic [14:0] PC_C = 15'h2345;
  localparam logic [14:0] PC_D = 15'h0456;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic        g;
    logic [14:0] pool [4];
    logic [31:0] tpool [3];
    void'($urandom(32'd20240611));
    pool[0] = PC_A; pool[1] = PC_B; pool[2] = PC_C; pool[3] = PC_D;
    tpool[0] = 32'h1000_0040; tpool[1] = 32'h2000_0013; tpool[2] = 32'h3000_007F;
    for (int i = 0; i < 256; i++) begin mValid[i] = 1'b0; mTag[i] = '0; mTgt[i] = '0; end
    mPir = '0; mLook = '0;
    rstN = 1'b0; lookupValid = 0; btbHit = 0; retValid = 0; retKind = 0;
    retTaken = 0; lookupPc = 0; retPc = 0; retTarget = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: empty after reset
    lookup(PC_A, 1'b1, "R1 reset lookup", g);
    check("R1 no hit after reset", {g, 32'd0}, {1'b0, 32'd0});

    // R7 train then hit with R5 hashing
    flush(); lookup(PC_A, 1'b1, "R7 miss before train", g);
    retire(2'd1, 1'b1, PC_A, tpool[0]);
    flush(); lookup(PC_A, 1'b1, "R7 hit after train", g);
    check("R7 trained entry hits", {g, 32'd0}, {1'b1, 32'd0});
    // R6: btbHit low suppresses
    flush(); lookup(PC_A, 1'b0, "R6 no btb hit", g);
    // R4: ignored kinds between flush and lookup
    flush();
    retire(2'd0, 1'b0, 15'h7777, 32'd0);
    retire(2'd2, 1'b1, 15'h1234, 32'h55);
    retire(2'd3, 1'b1, 15'h4321, 32'h66);
    retire(2'd1, 1'b0, 15'h0F0F, 32'h77);
    lookup(PC_A, 1'b1, "R4 ignored kinds keep path", g);
    check("R4 still hits", {g, 32'd0}, {1'b1, 32'd0});
    // R2: one extra taken conditional moves path
    flush(); retire(2'd0, 1'b1, 15'h0040, 32'd0);
    lookup(PC_A, 1'b1, "R2 taken cond changes path", g);
    // R9: different prefix then flush gives same hit
    retire(2'd0, 1'b1, 15'h5A5A, 32'd0); retire(2'd1, 1'b1, PC_D, 32'h9);
    flush(); lookup(PC_A, 1'b1, "R9 history depth", g);
    check("R9 old history gone", {g, 32'd0}, {1'b1, 32'd0});
    // R5 alias: PC_B shares index with PC_A, different tag
    flush(); lookup(PC_B, 1'b1, "R5 alias tag miss", g);
    check("R5 alias must miss", {g, 32'd0}, {1'b0, 32'd0});
    retire(2'd1, 1'b1, PC_B, tpool[1]);
    flush(); lookup(PC_A, 1'b1, "R7 alias overwrote entry", g);
    flush(); lookup(PC_B, 1'b1, "R5 alias now hits", g);
    // R7 retarget: mispredicted target replaced
    retire(2'd1, 1'b1, PC_B, tpool[2]);
    flush(); lookup(PC_B, 1'b1, "R7 new target", g);
    // R3: indirect updates path before lookup
    flush(); retire(2'd1, 1'b1, PC_C, tpool[0]);
    lookup(PC_B, 1'b1, "R3 indirect path update", g);

    // constrained random
    for (int it = 0; it < 500; it++) begin
      int r;
      r = int'($urandom % 8);
      if (r < 4) begin
        logic [14:0] pc;
        if ($urandom % 2) flush();
        pc = pool[$urandom % 4];
        lookup(pc, ($urandom % 5) != 0, "R8 random lookup", g);
        if (($urandom % 10) < 7) retire(2'd1, 1'b1, pc, tpool[$urandom % 3]);
      end else if (r < 6) begin
        retire(2'd0, 1'($urandom % 2), 15'($urandom), 32'd0);
      end else begin
        retire(2'd2 + 2'($urandom % 2), 1'($urandom % 2), 15'($urandom), $urandom);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule